// File: doc/BRIEF.md
# UART Fractional Baud Rate Generator

This block turns a peripheral clock into the one-cycle 16x oversampling enable that a UART shifter uses to sample and shift bits. The enable comes out of two stages in series. The first is a fractional pre-scaler. It drops a share of the clock cycles, which stretches the period by a factor of `1 + add/mul`. The second is a 16-bit integer divisor made from a high byte and a low byte. It counts only the cycles that the first stage lets through.

The sample enable rate is `f_clk / (D * (1 + add/mul))`, where `D = 256*hi + lo`. The UART bit rate is one sixteenth of that. The divisor bytes and the fractional fields are captured only on a load strobe, so software must change them only while the line is idle. A fractional setting that breaks the legality rules is not left undefined: the block runs it as if the fraction were zero. A divisor of zero runs as one.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the effective divisor is 1 and the fractional stage is off, so `tick16_o` is high on every clock.
- R2: With `frac_add_i` = 0, `tick16_o` pulses exactly once every D clocks, where D = 256*`div_hi_i` + `div_lo_i`. The first pulse comes D clocks after the load.
- R3: With a legal fraction, the number of pulses over N clocks after a load equals N*mul/((mul+add)*D). This holds exactly when N is a multiple of (mul+add)*D. A legal fraction has 1 <= mul <= 15, 0 <= add <= 14 and add < mul.
- R4: When the effective add value is 0, the fractional stage passes every clock through to the integer divisor.
- R5: An illegal fraction (mul = 0, or add >= mul) behaves exactly as add = 0.
- R6: A divisor value of 0 behaves as a divisor of 1.
- R7: Changes on the divisor and fraction inputs have no effect until `load_i` is high at a clock edge.
- R8: Two suppressed clocks from the fractional stage are never adjacent. When D > 1, `tick16_o` is never high on two consecutive clocks.
- R9: The captured configuration always satisfies add < mul, mul != 0 and divisor != 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_hi_i | input | 8 | Divisor high byte |
| div_lo_i | input | 8 | Divisor low byte |
| frac_mul_i | input | 4 | Fraction denominator term (mul) |
| frac_add_i | input | 4 | Fraction numerator term (add) |
| load_i | input | 1 | Capture strobe for divisor and fraction |
| tick16_o | output | 1 | One-cycle 16x sample enable |

## Verification
The bench counts pulses over windows that are exact multiples of (mul+add)*D, so any error in the wrap arithmetic of the accumulator shows up as a miscount:
- A stage that never swallowed a clock would report the plain integer rate.
- One that wrapped at the wrong modulus would drift by tens of pulses.

It also targets the following cases:
- **Illegal fractions (add equal to mul, mul of zero, add of 15).** A design without the fallback would stall, or divide by the raw garbage instead of running at the integer rate.
- **Divisor of zero.** A naive down-counter would hang here.
- **Large divisor through the high byte.** A swapped or truncated byte order would give a wildly wrong rate.
- **Input changes without a load.** These must leave the rate untouched, which catches a design that reads the inputs live.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned FRAC_W = 4;
  localparam int unsigned DIV_W  = 2 * BYTE_W;
  localparam int unsigned ACC_W  = FRAC_W + 1;
endpackage

// File: rtl/frac_cfg_reg.sv
module frac_cfg_reg #(
  parameter int unsigned BYTE_W = frac_baud_pkg::BYTE_W,
  parameter int unsigned FRAC_W = frac_baud_pkg::FRAC_W,
  localparam int unsigned DIV_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] div_hi_i,
  input  logic [BYTE_W-1:0] div_lo_i,
  input  logic [FRAC_W-1:0] mul_i,
  input  logic [FRAC_W-1:0] add_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [FRAC_W-1:0] mul_o,
  output logic [FRAC_W-1:0] add_o
);
  logic [DIV_W-1:0]  raw_div;
  logic [DIV_W-1:0]  div_n;
  logic [FRAC_W-1:0] mul_n;
  logic [FRAC_W-1:0] add_n;
  logic              legal;

  always_comb begin
    raw_div = {div_hi_i, div_lo_i};
    div_n   = (raw_div == '0) ? DIV_W'(1) : raw_div;
    legal   = (mul_i != '0) && (add_i < mul_i);
    mul_n   = (mul_i == '0) ? FRAC_W'(1) : mul_i;
    // illegal fraction falls back to bypass
    add_n   = legal ? add_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o <= DIV_W'(1);
      mul_o <= FRAC_W'(1);
      add_o <= '0;
    end else if (load_i) begin
      div_o <= div_n;
      mul_o <= mul_n;
      add_o <= add_n;
    end
  end
endmodule

// File: rtl/frac_prescaler.sv
module frac_prescaler #(
  parameter int unsigned FRAC_W = frac_baud_pkg::FRAC_W,
  localparam int unsigned ACC_W = FRAC_W + 1,
  localparam int unsigned SUM_W = ACC_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [FRAC_W-1:0] mul_i,
  input  logic [FRAC_W-1:0] add_i,
  output logic              en_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic [SUM_W-1:0] modulus;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] wrapped;
  logic             wrap;

  always_comb begin
    modulus = SUM_W'(mul_i) + SUM_W'(add_i);
    sum     = SUM_W'(acc_q) + SUM_W'(add_i);
    wrap    = (sum >= modulus);
    wrapped = sum - modulus;
    en_o    = ~wrap;
    if (restart_i)  acc_d = '0;
    else if (wrap)  acc_d = wrapped[ACC_W-1:0];
    else            acc_d = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end
endmodule

// File: rtl/int_divider.sv
module int_divider #(
  parameter int unsigned DIV_W = frac_baud_pkg::DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             term;

  // >= keeps a shrunken divisor from stalling the count
  assign term = en_i && (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= DIV_W'(1);
      tick_o <= 1'b0;
    end else if (restart_i) begin
      cnt_q  <= DIV_W'(1);
      tick_o <= 1'b0;
    end else begin
      tick_o <= term;
      if (term)      cnt_q <= DIV_W'(1);
      else if (en_i) cnt_q <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int unsigned BYTE_W = frac_baud_pkg::BYTE_W,
  parameter int unsigned FRAC_W = frac_baud_pkg::FRAC_W,
  localparam int unsigned DIV_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] div_hi_i,
  input  logic [BYTE_W-1:0] div_lo_i,
  input  logic [FRAC_W-1:0] frac_mul_i,
  input  logic [FRAC_W-1:0] frac_add_i,
  input  logic              load_i,
  output logic              tick16_o
);
  logic [DIV_W-1:0]  cfg_div;
  logic [FRAC_W-1:0] cfg_mul;
  logic [FRAC_W-1:0] cfg_add;
  logic              frac_en;

  frac_cfg_reg #(.BYTE_W(BYTE_W), .FRAC_W(FRAC_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_i),
    .div_hi_i (div_hi_i),
    .div_lo_i (div_lo_i),
    .mul_i    (frac_mul_i),
    .add_i    (frac_add_i),
    .div_o    (cfg_div),
    .mul_o    (cfg_mul),
    .add_o    (cfg_add)
  );

  frac_prescaler #(.FRAC_W(FRAC_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (load_i),
    .mul_i     (cfg_mul),
    .add_i     (cfg_add),
    .en_o      (frac_en)
  );

  int_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (load_i),
    .en_i      (frac_en),
    .div_i     (cfg_div),
    .tick_o    (tick16_o)
  );
endmodule

// File: rtl/frac_baud_chk.sv
module frac_baud_chk #(
  parameter int unsigned DIV_W  = frac_baud_pkg::DIV_W,
  parameter int unsigned FRAC_W = frac_baud_pkg::FRAC_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic              tick16_o,
  input logic              frac_en,
  input logic [DIV_W-1:0]  cfg_div,
  input logic [FRAC_W-1:0] cfg_mul,
  input logic [FRAC_W-1:0] cfg_add
);
  // R9
  cfg_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mul != '0) && (cfg_add < cfg_mul) && (cfg_div != '0));

  // R4
  bypass_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_add == '0) |-> frac_en);

  // R8
  gap_isolated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frac_en |=> frac_en);

  // R8
  single_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick16_o && (cfg_div > DIV_W'(1)) && !load_i) |=> !tick16_o);

  // R7
  hold_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cfg_div) && $stable(cfg_mul) && $stable(cfg_add));
endmodule

bind frac_baud_gen frac_baud_chk #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .load_i   (load_i),
  .tick16_o (tick16_o),
  .frac_en  (frac_en),
  .cfg_div  (cfg_div),
  .cfg_mul  (cfg_mul),
  .cfg_add  (cfg_add)
);

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] div_hi_i = '0;
  logic [7:0] div_lo_i = '0;
  logic [3:0] frac_mul_i = '0;
  logic [3:0] frac_add_i = '0;
  logic       load_i = 1'b0;
  logic       tick16_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk_i = ~clk_i;

  frac_baud_gen u0 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .div_hi_i   (div_hi_i),
    .div_lo_i   (div_lo_i),
    .frac_mul_i (frac_mul_i),
    .frac_add_i (frac_add_i),
    .load_i     (load_i),
    .tick16_o   (tick16_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_cfg(input int div, input int mul, input int add);
    @(negedge clk_i);
    div_hi_i   = 8'(div >> 8);
    div_lo_i   = 8'(div);
    frac_mul_i = 4'(mul);
    frac_add_i = 4'(add);
    load_i     = 1'b1;
    @(negedge clk_i);
    load_i     = 1'b0;
  endtask

  task automatic count_ticks(input int ncyc, output int n);
    n = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk_i);
      if (tick16_o) n++;
    end
  endtask

  task automatic rate_case(input string req, input int div, input int mul, input int add,
                           input int ncyc, input int exp);
    int n;
    load_cfg(div, mul, add);
    count_ticks(ncyc, n);
    check((n >= exp - 1) && (n <= exp + 1), req, n, exp);
  endtask

  task automatic test_reset();
    int n;
    count_ticks(20, n);
    check(n == 20, "R1 reset every-cycle", n, 20);
  endtask

  task automatic test_integer_period();
    int first = -1;
    int last = -1;
    int gap_bad = 0;
    int n = 0;
    load_cfg(3, 1, 0);
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk_i);
      if (tick16_o) begin
        if (first < 0) first = i;
        else if (i - last != 3) gap_bad++;
        last = i;
        n++;
      end
    end
    check(first == 3, "R2 first tick", first, 3);
    check(gap_bad == 0, "R2 tick spacing", gap_bad, 0);
    check(n == 10, "R2 tick count", n, 10);
  endtask

  task automatic test_fraction();
    // R4 bypass: add=0 gives the plain integer rate
    rate_case("R4 bypass", 7, 9, 0, 700, 100);
    // R3 windows are multiples of (mul+add)*D
    rate_case("R3 frac 2/1 D4", 4, 2, 1, 1200, 200);
    rate_case("R3 frac 15/14 D5", 5, 15, 14, 2900, 300);
    rate_case("R3 frac 7/3 D2", 2, 7, 3, 2000, 700);
    rate_case("R3 high byte D260", 260, 3, 1, 10400, 30);
  endtask

  task automatic test_illegal();
    rate_case("R5 add==mul", 10, 4, 4, 1000, 100);
    rate_case("R5 mul zero", 10, 0, 2, 1000, 100);
    rate_case("R5 add 15", 10, 9, 15, 1000, 100);
  endtask

  task automatic test_zero_div();
    rate_case("R6 divisor zero", 0, 1, 0, 50, 50);
  endtask

  task automatic test_no_load();
    int n;
    load_cfg(5, 1, 0);
    @(negedge clk_i);
    div_lo_i   = 8'd1;
    frac_mul_i = 4'd3;
    frac_add_i = 4'd2;
    count_ticks(500, n);
    check((n >= 99) && (n <= 101), "R7 inputs ignored without load", n, 100);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        test_reset();
        test_integer_period();
        test_fraction();
        test_illegal();
        test_zero_div();
        test_no_load();
      end
      begin
        repeat (150000) @(posedge clk_i);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule